// File: doc/BRIEF.md
# Audio codec control register decoder

This block is the write-only control register file of a stereo audio codec. It sits behind a byte-stream slave bus back end (for example an I2C target) that delivers a start indication and a stream of data bytes. Every control transfer is exactly two bytes. The first byte carries a 7-bit register address in its upper seven bits, and its lowest bit is the top bit of a 9-bit value. The second byte supplies the other eight value bits.

A small receive state machine frames the byte stream. Its states are `RX_HEAD` (waiting for the address byte), `RX_BODY` (waiting for the value byte) and `RX_FULL` (frame complete, further bytes refused). A start moves any state to `RX_HEAD`. An accepted byte moves `RX_HEAD` to `RX_BODY` and `RX_BODY` to `RX_FULL`. `RX_FULL` stays in place until the next start. Each completed frame makes a register bank update the addressed fields: input gain and mute, digital and analog volumes, DAC mute and ADC polarity, codec enable and power bits, interface format with master select, and the sample-rate code. The bank also pulses a strobe for each group of fields that was written. A write to the soft-reset address returns every field to its power-on default.

Top module: `codec_ctl_regs`

## Requirements
- R1: A frame is two accepted bytes. The address is byte0[7:1]. The 9-bit value is {byte0[0], byte1[7:0]}.
- R2: `bus_start` returns the framer to `RX_HEAD`. Any byte after the second byte of a frame gets `byte_accept` low and changes no field. A frame that a start cuts off after its first byte writes nothing.
- R3: Hardware reset and a write of any value to address 0x0F give the same defaults. Input PGA volumes are 0x17, ADC digital volumes 0xC3, DAC digital volumes 0xFF and every analog output volume 0x79. The format word is 0x0A (so master is 0), DAC mute is 1, and the rate code, enable, power bits, ADC polarity and both input mutes are 0. A soft reset pulses all five strobe bits.
- R4: Address 0x00 (left) and address 0x01 (right) set the input PGA volume from value[5:0] and the input mute from value[7].
- R5: Seven-bit analog volumes come from value[6:0]: 0x02/0x03 set headphone left/right, 0x28/0x29 set speaker left/right, and 0x2A sets mono.
- R6: Addresses 0x0A/0x0B set DAC digital volume left/right and 0x15/0x16 set ADC digital volume left/right, each from value[7:0].
- R7: Address 0x05 sets the DAC mute from value[3] and the ADC polarity from value[6:5].
- R8: Address 0x19 sets the codec enable to 1 exactly when value[8:6] equals 3, and to 0 otherwise. Address 0x1A stores the power bits as value & 0x07E.
- R9: Address 0x07 stores the whole 9-bit value as the format word, and `master_mode` equals format bit 6. Address 0x08 sets the rate code from value[5:1].
- R10: A frame to an address not listed in R3 to R9 is accepted, changes no field and raises no strobe.
- R11: Fields change at the same clock edge that accepts the second byte, and `upd_stb` pulses for exactly one cycle at that edge. The strobe bits are: bit 0 for input gain (0x00, 0x01, 0x15, 0x16), bit 1 for output level (0x02, 0x03, 0x0A, 0x0B, 0x28, 0x29, 0x2A), bit 2 for mute/polarity (0x05), bit 3 for power (0x19, 0x1A) and bit 4 for clocking (0x07, 0x08).
- R12: A byte presented in the same cycle as `bus_start` is refused, and the next accepted byte is taken as the address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | Start of a bus transfer, one-cycle pulse |
| byte_valid | input | 1 | A received byte is presented |
| byte_data | input | 8 | Received byte |
| byte_accept | output | 1 | Byte taken (high) or refused (low) |
| in_vol_l | output | 6 | Left input PGA volume |
| in_vol_r | output | 6 | Right input PGA volume |
| in_mute_l | output | 1 | Left input mute |
| in_mute_r | output | 1 | Right input mute |
| adc_vol_l | output | 8 | Left ADC digital volume |
| adc_vol_r | output | 8 | Right ADC digital volume |
| dac_vol_l | output | 8 | Left DAC digital volume |
| dac_vol_r | output | 8 | Right DAC digital volume |
| hp_vol_l | output | 7 | Headphone left volume |
| hp_vol_r | output | 7 | Headphone right volume |
| spk_vol_l | output | 7 | Speaker left volume |
| spk_vol_r | output | 7 | Speaker right volume |
| mono_vol | output | 7 | Mono output volume |
| dac_mute | output | 1 | DAC soft mute |
| adc_pol | output | 2 | ADC polarity select |
| codec_en | output | 1 | Codec enable derived from the power field |
| pwr_ctl | output | 9 | Masked power bits |
| fmt_word | output | 9 | Interface format word |
| master_mode | output | 1 | Master clocking selected |
| rate_code | output | 5 | Sample-rate code |
| upd_stb | output | 5 | One-cycle per-group update strobes |

## Verification
The hardest conditions to reach from the ports are those where framing and bus starts fall out of step. These are a third byte after a complete frame, a start that arrives between the two bytes of a frame, and a start that coincides with a byte. Directed sequences drive each of these on purpose. They then send a good frame and check which field changed. This shows whether a stray byte was taken as an address byte or dropped.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int VAL_W  = 9;
    localparam int PGA_W  = 6;
    localparam int OUT_W  = 7;
    localparam int DIG_W  = 8;
    localparam int RATE_W = 5;
    localparam int POL_W  = 2;
    localparam int NGRP   = 5;

    localparam int G_IN   = 0;
    localparam int G_OUT  = 1;
    localparam int G_MUTE = 2;
    localparam int G_PWR  = 3;
    localparam int G_CLK  = 4;

    localparam logic [ADDR_W-1:0] AD_PGA_L    = 7'h00;
    localparam logic [ADDR_W-1:0] AD_PGA_R    = 7'h01;
    localparam logic [ADDR_W-1:0] AD_HP_L     = 7'h02;
    localparam logic [ADDR_W-1:0] AD_HP_R     = 7'h03;
    localparam logic [ADDR_W-1:0] AD_MUTE     = 7'h05;
    localparam logic [ADDR_W-1:0] AD_FMT      = 7'h07;
    localparam logic [ADDR_W-1:0] AD_RATE     = 7'h08;
    localparam logic [ADDR_W-1:0] AD_DAC_L    = 7'h0A;
    localparam logic [ADDR_W-1:0] AD_DAC_R    = 7'h0B;
    localparam logic [ADDR_W-1:0] AD_SOFT_RST = 7'h0F;
    localparam logic [ADDR_W-1:0] AD_ADC_L    = 7'h15;
    localparam logic [ADDR_W-1:0] AD_ADC_R    = 7'h16;
    localparam logic [ADDR_W-1:0] AD_PWR_EN   = 7'h19;
    localparam logic [ADDR_W-1:0] AD_PWR_BITS = 7'h1A;
    localparam logic [ADDR_W-1:0] AD_SPK_L    = 7'h28;
    localparam logic [ADDR_W-1:0] AD_SPK_R    = 7'h29;
    localparam logic [ADDR_W-1:0] AD_MONO     = 7'h2A;

    localparam logic [VAL_W-1:0] PWR_MASK = 9'h07E;

    typedef enum logic [1:0] {
        RX_HEAD = 2'd0,
        RX_BODY = 2'd1,
        RX_FULL = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic [PGA_W-1:0]  pga_l;
        logic [PGA_W-1:0]  pga_r;
        logic              pga_mute_l;
        logic              pga_mute_r;
        logic [DIG_W-1:0]  adc_l;
        logic [DIG_W-1:0]  adc_r;
        logic [DIG_W-1:0]  dac_l;
        logic [DIG_W-1:0]  dac_r;
        logic [OUT_W-1:0]  hp_l;
        logic [OUT_W-1:0]  hp_r;
        logic [OUT_W-1:0]  spk_l;
        logic [OUT_W-1:0]  spk_r;
        logic [OUT_W-1:0]  mono;
        logic              dac_mute;
        logic [POL_W-1:0]  adc_pol;
        logic              en;
        logic [VAL_W-1:0]  pwr;
        logic [VAL_W-1:0]  fmt;
        logic [RATE_W-1:0] rate;
    } ctl_t;

    function automatic ctl_t ctl_defaults();
        ctl_t d;
        d            = '0;
        d.pga_l      = 6'h17;
        d.pga_r      = 6'h17;
        d.adc_l      = 8'hC3;
        d.adc_r      = 8'hC3;
        d.dac_l      = 8'hFF;
        d.dac_r      = 8'hFF;
        d.hp_l       = 7'h79;
        d.hp_r       = 7'h79;
        d.spk_l      = 7'h79;
        d.spk_r      = 7'h79;
        d.mono       = 7'h79;
        d.dac_mute   = 1'b1;
        d.fmt        = 9'h00A;
        return d;
    endfunction

    function automatic logic [NGRP-1:0] group_mask(logic [ADDR_W-1:0] a);
        logic [NGRP-1:0] m;
        m = '0;
        case (a)
            AD_PGA_L, AD_PGA_R, AD_ADC_L, AD_ADC_R:            m[G_IN]   = 1'b1;
            AD_HP_L, AD_HP_R, AD_DAC_L, AD_DAC_R,
            AD_SPK_L, AD_SPK_R, AD_MONO:                       m[G_OUT]  = 1'b1;
            AD_MUTE:                                           m[G_MUTE] = 1'b1;
            AD_PWR_EN, AD_PWR_BITS:                            m[G_PWR]  = 1'b1;
            AD_FMT, AD_RATE:                                   m[G_CLK]  = 1'b1;
            AD_SOFT_RST:                                       m         = '1;
            default:                                           m         = '0;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/codec_frame_rx.sv
module codec_frame_rx
    import codec_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              byte_accept,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [VAL_W-1:0]  wr_val
);
    rx_state_e         state_q, state_d;
    logic [BYTE_W-1:0] head_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_HEAD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                head_q <= '0;
        else if (byte_accept && state_q == RX_HEAD) head_q <= byte_data;
    end

    always_comb begin
        state_d = state_q;
        if (bus_start) begin
            state_d = RX_HEAD;
        end else if (byte_valid) begin
            unique case (state_q)
                RX_HEAD: state_d = RX_BODY;
                RX_BODY: state_d = RX_FULL;
                RX_FULL: state_d = RX_FULL;
                default: state_d = RX_HEAD;
            endcase
        end
    end

    always_comb begin
        byte_accept = byte_valid && !bus_start && (state_q != RX_FULL);
        wr_fire     = byte_accept && (state_q == RX_BODY);
        wr_addr     = head_q[BYTE_W-1:1];
        wr_val      = {head_q[0], byte_data};
    end

    // R2
    one_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> !wr_fire);

    // R2
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_FULL && !bus_start) |=> (state_q == RX_FULL));
endmodule

// File: rtl/codec_reg_bank.sv
module codec_reg_bank
    import codec_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [VAL_W-1:0]  wr_val,
    output ctl_t              fld_q,
    output logic [NGRP-1:0]   upd_stb
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q <= ctl_defaults();
        end else if (wr_fire) begin
            case (wr_addr)
                AD_PGA_L: begin
                    fld_q.pga_l      <= wr_val[PGA_W-1:0];
                    fld_q.pga_mute_l <= wr_val[7];
                end
                AD_PGA_R: begin
                    fld_q.pga_r      <= wr_val[PGA_W-1:0];
                    fld_q.pga_mute_r <= wr_val[7];
                end
                AD_HP_L:     fld_q.hp_l  <= wr_val[OUT_W-1:0];
                AD_HP_R:     fld_q.hp_r  <= wr_val[OUT_W-1:0];
                AD_SPK_L:    fld_q.spk_l <= wr_val[OUT_W-1:0];
                AD_SPK_R:    fld_q.spk_r <= wr_val[OUT_W-1:0];
                AD_MONO:     fld_q.mono  <= wr_val[OUT_W-1:0];
                AD_DAC_L:    fld_q.dac_l <= wr_val[DIG_W-1:0];
                AD_DAC_R:    fld_q.dac_r <= wr_val[DIG_W-1:0];
                AD_ADC_L:    fld_q.adc_l <= wr_val[DIG_W-1:0];
                AD_ADC_R:    fld_q.adc_r <= wr_val[DIG_W-1:0];
                AD_MUTE: begin
                    fld_q.dac_mute <= wr_val[3];
                    fld_q.adc_pol  <= wr_val[6:5];
                end
                AD_PWR_EN:   fld_q.en   <= (wr_val[8:6] == 3'd3);
                AD_PWR_BITS: fld_q.pwr  <= wr_val & PWR_MASK;
                AD_FMT:      fld_q.fmt  <= wr_val;
                AD_RATE:     fld_q.rate <= wr_val[RATE_W:1];
                AD_SOFT_RST: fld_q      <= ctl_defaults();
                default:     fld_q      <= fld_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       upd_stb <= '0;
        else if (wr_fire) upd_stb <= group_mask(wr_addr);
        else              upd_stb <= '0;
    end

    // R3
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && wr_addr == AD_SOFT_RST) |=>
            (fld_q.dac_mute && fld_q.rate == '0 && !fld_q.en
             && fld_q.fmt == 9'h00A && upd_stb == '1));

    // R8
    en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fld_q.en) |-> $past(wr_fire && wr_addr == AD_PWR_EN && wr_val[8:6] == 3'd3));

    // R10
    undecoded_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && group_mask(wr_addr) == '0) |=> (upd_stb == '0 && $stable(fld_q)));

    // R11
    stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && wr_addr != AD_SOFT_RST) |=> $onehot0(upd_stb));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> (upd_stb == '0 && $stable(fld_q)));
endmodule

// File: rtl/codec_ctl_regs.sv
module codec_ctl_regs
    import codec_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              byte_accept,
    output logic [PGA_W-1:0]  in_vol_l,
    output logic [PGA_W-1:0]  in_vol_r,
    output logic              in_mute_l,
    output logic              in_mute_r,
    output logic [DIG_W-1:0]  adc_vol_l,
    output logic [DIG_W-1:0]  adc_vol_r,
    output logic [DIG_W-1:0]  dac_vol_l,
    output logic [DIG_W-1:0]  dac_vol_r,
    output logic [OUT_W-1:0]  hp_vol_l,
    output logic [OUT_W-1:0]  hp_vol_r,
    output logic [OUT_W-1:0]  spk_vol_l,
    output logic [OUT_W-1:0]  spk_vol_r,
    output logic [OUT_W-1:0]  mono_vol,
    output logic              dac_mute,
    output logic [POL_W-1:0]  adc_pol,
    output logic              codec_en,
    output logic [VAL_W-1:0]  pwr_ctl,
    output logic [VAL_W-1:0]  fmt_word,
    output logic              master_mode,
    output logic [RATE_W-1:0] rate_code,
    output logic [NGRP-1:0]   upd_stb
);
    logic              wr_fire;
    logic [ADDR_W-1:0] wr_addr;
    logic [VAL_W-1:0]  wr_val;
    ctl_t              fld;

    codec_frame_rx u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_start   (bus_start),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .byte_accept (byte_accept),
        .wr_fire     (wr_fire),
        .wr_addr     (wr_addr),
        .wr_val      (wr_val)
    );

    codec_reg_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_fire (wr_fire),
        .wr_addr (wr_addr),
        .wr_val  (wr_val),
        .fld_q   (fld),
        .upd_stb (upd_stb)
    );

    assign in_vol_l    = fld.pga_l;
    assign in_vol_r    = fld.pga_r;
    assign in_mute_l   = fld.pga_mute_l;
    assign in_mute_r   = fld.pga_mute_r;
    assign adc_vol_l   = fld.adc_l;
    assign adc_vol_r   = fld.adc_r;
    assign dac_vol_l   = fld.dac_l;
    assign dac_vol_r   = fld.dac_r;
    assign hp_vol_l    = fld.hp_l;
    assign hp_vol_r    = fld.hp_r;
    assign spk_vol_l   = fld.spk_l;
    assign spk_vol_r   = fld.spk_r;
    assign mono_vol    = fld.mono;
    assign dac_mute    = fld.dac_mute;
    assign adc_pol     = fld.adc_pol;
    assign codec_en    = fld.en;
    assign pwr_ctl     = fld.pwr;
    assign fmt_word    = fld.fmt;
    assign master_mode = fld.fmt[6];
    assign rate_code   = fld.rate;
endmodule

// File: tb/codec_ctl_regs_tb.sv
module codec_ctl_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_start = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;

    logic       byte_accept;
    logic [5:0] in_vol_l, in_vol_r;
    logic       in_mute_l, in_mute_r;
    logic [7:0] adc_vol_l, adc_vol_r, dac_vol_l, dac_vol_r;
    logic [6:0] hp_vol_l, hp_vol_r, spk_vol_l, spk_vol_r, mono_vol;
    logic       dac_mute;
    logic [1:0] adc_pol;
    logic       codec_en;
    logic [8:0] pwr_ctl, fmt_word;
    logic       master_mode;
    logic [4:0] rate_code;
    logic [4:0] upd_stb;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    codec_ctl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_accept(byte_accept),
        .in_vol_l(in_vol_l), .in_vol_r(in_vol_r), .in_mute_l(in_mute_l), .in_mute_r(in_mute_r),
        .adc_vol_l(adc_vol_l), .adc_vol_r(adc_vol_r), .dac_vol_l(dac_vol_l), .dac_vol_r(dac_vol_r),
        .hp_vol_l(hp_vol_l), .hp_vol_r(hp_vol_r), .spk_vol_l(spk_vol_l), .spk_vol_r(spk_vol_r),
        .mono_vol(mono_vol), .dac_mute(dac_mute), .adc_pol(adc_pol), .codec_en(codec_en),
        .pwr_ctl(pwr_ctl), .fmt_word(fmt_word), .master_mode(master_mode),
        .rate_code(rate_code), .upd_stb(upd_stb)
    );

    // row: addr[33:27] value[26:18] strobe[17:13] select[12:9] expected[8:0]
    localparam int NV = 20;
    localparam logic [33:0] TBL [NV] = '{
        {7'h00, 9'h0A5, 5'b00001, 4'd0,  9'h025},  // R1 R4 left PGA volume
        {7'h00, 9'h080, 5'b00001, 4'd1,  9'h001},  // R4 left PGA mute
        {7'h01, 9'h13F, 5'b00001, 4'd2,  9'h03F},  // R1 R4 right PGA, value bit 8 used
        {7'h02, 9'h1FF, 5'b00010, 4'd3,  9'h07F},  // R5 headphone left
        {7'h03, 9'h005, 5'b00010, 4'd15, 9'h005},  // R5 headphone right
        {7'h29, 9'h055, 5'b00010, 4'd4,  9'h055},  // R5 speaker right
        {7'h2A, 9'h133, 5'b00010, 4'd5,  9'h033},  // R5 mono
        {7'h0A, 9'h1C8, 5'b00010, 4'd6,  9'h0C8},  // R6 DAC left
        {7'h16, 9'h012, 5'b00001, 4'd7,  9'h012},  // R6 ADC right
        {7'h05, 9'h060, 5'b00100, 4'd8,  9'h000},  // R7 DAC mute clear
        {7'h05, 9'h068, 5'b00100, 4'd9,  9'h003},  // R7 ADC polarity
        {7'h19, 9'h0C0, 5'b01000, 4'd10, 9'h001},  // R8 enable code 3
        {7'h19, 9'h1C0, 5'b01000, 4'd10, 9'h000},  // R8 enable code 7
        {7'h1A, 9'h1FF, 5'b01000, 4'd11, 9'h07E},  // R8 power mask
        {7'h07, 9'h04A, 5'b10000, 4'd12, 9'h04A},  // R9 format word
        {7'h07, 9'h14A, 5'b10000, 4'd13, 9'h001},  // R9 master bit
        {7'h08, 9'h03E, 5'b10000, 4'd14, 9'h01F},  // R9 rate code
        {7'h08, 9'h1D5, 5'b10000, 4'd14, 9'h00A},  // R1 R9 rate code
        {7'h3F, 9'h1FF, 5'b00000, 4'd14, 9'h00A},  // R10 undecoded, rate held
        {7'h11, 9'h1FF, 5'b00000, 4'd12, 9'h14A}   // R10 undecoded, format held
    };

    function automatic logic [8:0] get_field(input logic [3:0] sel);
        case (sel)
            4'd0:  return {3'b0, in_vol_l};
            4'd1:  return {8'b0, in_mute_l};
            4'd2:  return {3'b0, in_vol_r};
            4'd3:  return {2'b0, hp_vol_l};
            4'd4:  return {2'b0, spk_vol_r};
            4'd5:  return {2'b0, mono_vol};
            4'd6:  return {1'b0, dac_vol_l};
            4'd7:  return {1'b0, adc_vol_r};
            4'd8:  return {8'b0, dac_mute};
            4'd9:  return {7'b0, adc_pol};
            4'd10: return {8'b0, codec_en};
            4'd11: return pwr_ctl;
            4'd12: return fmt_word;
            4'd13: return {8'b0, master_mode};
            4'd14: return {4'b0, rate_code};
            default: return {2'b0, hp_vol_r};
        endcase
    endfunction

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acc);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = b;
        #1 acc = byte_accept;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        bus_start = 1'b1;
        @(negedge clk);
        bus_start = 1'b0;
    endtask

    task automatic frame(input logic [6:0] a, input logic [8:0] v);
        logic acc;
        pulse_start();
        send_byte({a, v[8]}, acc);
        send_byte(v[7:0], acc);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic acc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 hardware reset defaults
        chk("R3 reset in_vol_l",  {3'b0, in_vol_l},  9'h017);
        chk("R3 reset adc_vol_r", {1'b0, adc_vol_r}, 9'h0C3);
        chk("R3 reset dac_vol_l", {1'b0, dac_vol_l}, 9'h0FF);
        chk("R3 reset mono_vol",  {2'b0, mono_vol},  9'h079);
        chk("R3 reset fmt_word",  fmt_word,          9'h00A);
        chk("R3 reset dac_mute",  {8'b0, dac_mute},  9'h001);
        chk("R3 reset rate/en",   {3'b0, rate_code, codec_en}, 9'h000);
        chk("R3 reset strobe",    {4'b0, upd_stb},   9'h000);

        // R1 R4 R5 R6 R7 R8 R9 R10 R11 table walk
        for (int i = 0; i < NV; i++) begin
            frame(TBL[i][33:27], TBL[i][26:18]);
            chk($sformatf("table row %0d field", i), get_field(TBL[i][12:9]), TBL[i][8:0]);
            chk($sformatf("R11 row %0d strobe", i), {4'b0, upd_stb}, {4'b0, TBL[i][17:13]});
            @(negedge clk);
            chk($sformatf("R11 row %0d strobe drop", i), {4'b0, upd_stb}, 9'h000);
        end

        // R2 third byte refused and ignored
        frame(7'h00, 9'h011);
        send_byte(8'h3A, acc);
        chk("R2 third byte refused", {8'b0, acc}, 9'h000);
        chk("R2 third byte no change", {3'b0, in_vol_l}, 9'h011);
        chk("R2 third byte no strobe", {4'b0, upd_stb}, 9'h000);

        // R2 start between the bytes of a frame
        pulse_start();
        send_byte({7'h08, 1'b0}, acc);
        pulse_start();
        send_byte({7'h00, 1'b0}, acc);
        chk("R2 head after restart accepted", {8'b0, acc}, 9'h001);
        send_byte(8'h2A, acc);
        chk("R2 restart writes new address", {3'b0, in_vol_l}, 9'h02A);
        chk("R2 cut frame wrote nothing", {4'b0, rate_code}, 9'h00A);

        // R12 byte coincident with start
        @(negedge clk);
        bus_start  = 1'b1;
        byte_valid = 1'b1;
        byte_data  = {7'h08, 1'b0};
        #1 acc = byte_accept;
        @(negedge clk);
        bus_start  = 1'b0;
        byte_valid = 1'b0;
        chk("R12 byte with start refused", {8'b0, acc}, 9'h000);
        send_byte({7'h00, 1'b0}, acc);
        send_byte(8'h15, acc);
        chk("R12 next byte is the head", {3'b0, in_vol_l}, 9'h015);
        chk("R12 rate untouched", {4'b0, rate_code}, 9'h00A);

        // R3 soft reset
        frame(7'h0F, 9'h1A5);
        chk("R3 soft reset in_vol_l", {3'b0, in_vol_l}, 9'h017);
        chk("R3 soft reset pwr",      pwr_ctl, 9'h000);
        chk("R3 soft reset fmt",      fmt_word, 9'h00A);
        chk("R3 soft reset master",   {8'b0, master_mode}, 9'h000);
        chk("R3 soft reset dac_mute", {8'b0, dac_mute}, 9'h001);
        chk("R3 soft reset adc_vol_r",{1'b0, adc_vol_r}, 9'h0C3);
        chk("R3 soft reset strobes",  {4'b0, upd_stb}, 9'h01F);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule